// File: doc/BRIEF.md
# Encrypted Frequent Value Matcher

This block shortens the read path of a memory that is protected by a block cipher applied directly to each data block, with no counter. A small table holds a set of frequently seen plaintext values next to their encrypted forms. An outside cipher pipeline fills the table. For each frequent value it returns the ciphertext together with the entry number it belongs to. When a ciphertext block comes back from memory, its ciphertext is compared in parallel against every stored ciphertext. On a match, the plaintext is available one cycle later, without waiting for the long decryption pipeline.

A lookup is tried only when the per-block frequent-value map bit that comes with the fetched block is set. A block whose map bit is clear goes past the table and never reports a hit. The block has two cipher widths. The narrow width has 64-bit blocks. The wide width has 128-bit blocks, and in this width each entry holds an encrypted pair of 64-bit frequent values. A fetched block hits only when both of its halves match the same entry. The table depth is 8, 16 or 32 entries.

The result path is a four-state register: IDLE, BYPASS, MISS and HIT. Each clock it takes one of four transitions. It goes to IDLE when no lookup is presented. It goes to BYPASS when a lookup arrives with its map bit clear. It goes to HIT when the lookup finds a valid matching entry. It goes to MISS in every other lookup case. Any state can reach any state in one cycle.

Top module: `fvm_matcher`

## Requirements
- R1: After reset every table entry is invalid, out_valid is 0, and a lookup of any ciphertext (including all zeros) with the map bit set reports out_hit = 0.
- R2: A fill with fill_valid = 1 writes fill_plain and fill_cipher into entry fill_index and marks it valid. A later lookup of that ciphertext reports out_hit = 1, out_index = fill_index and out_plain = fill_plain.
- R3: out_valid is 1 in exactly the cycle after a cycle with lk_valid = 1, and 0 after a cycle with lk_valid = 0. out_hit is never 1 while out_valid is 0.
- R4: A lookup with lk_map_bit = 0 takes the BYPASS transition. It reports out_valid = 1, out_hit = 0, out_index = 0 and out_plain = 0, even when lk_cipher matches a valid entry.
- R5: A lookup that matches no valid entry reports out_hit = 0, out_index = 0 and out_plain = 0.
- R6: When several valid entries hold the looked-up ciphertext, the lowest-numbered one is returned.
- R7: A key_change pulse invalidates every entry at the next clock edge. A fill in the same cycle as key_change is dropped. A lookup in that same cycle still sees the old contents.
- R8: A fill and a lookup in the same cycle that touch the same entry return the entry's contents from before the fill.
- R9: In the wide width (WIDE_MODE = 1, 128-bit blocks, plaintext = {upper 64-bit value, lower 64-bit value}), a lookup hits only when both 64-bit halves equal the same entry. A match on one half alone is a miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_change | input | 1 | Pulse that invalidates the whole table |
| fill_valid | input | 1 | Write strobe from the cipher pipeline |
| fill_index | input | IDX_W | Entry to write |
| fill_plain | input | BLK_W | Frequent plaintext value (pair in wide width) |
| fill_cipher | input | BLK_W | Its encrypted form |
| lk_valid | input | 1 | Lookup strobe |
| lk_map_bit | input | 1 | Frequent-value map bit of the fetched block |
| lk_cipher | input | BLK_W | Fetched ciphertext block |
| out_valid | output | 1 | Result strobe, one cycle after lk_valid |
| out_hit | output | 1 | Lookup matched a valid entry |
| out_index | output | IDX_W | Winning entry number, 0 when no hit |
| out_plain | output | BLK_W | Plaintext of the winning entry, 0 when no hit |

## Verification
The bench aims at the cases where a matcher goes wrong without anyone noticing. One is a lookup on an all-zero ciphertext straight after reset: a design that ignored the valid bits would hit the zeroed storage. Another is a block whose ciphertext matches while its map bit is clear: a design that skipped the gate would return plaintext it should not. Several entries hold the same ciphertext, so an encoder that favours the top entry returns the wrong index. A fill and a lookup on the same entry in the same cycle show whether the new data leaks through too early. Key changes with a fill in the same cycle show whether a dropped write still turns valid. Wide blocks that match on a single half catch a compare that checks only one half.

// File: rtl/fvm_pkg.sv
package fvm_pkg;

    typedef enum logic [1:0] {
        RES_IDLE   = 2'd0,
        RES_BYPASS = 2'd1,
        RES_MISS   = 2'd2,
        RES_HIT    = 2'd3
    } res_state_e;

    function automatic int unsigned blk_width(input int unsigned half_w, input bit wide);
        return wide ? 2 * half_w : half_w;
    endfunction

endpackage

// File: rtl/fvm_entry_store.sv
module fvm_entry_store #(
    parameter int unsigned N_ENT = 8,
    parameter int unsigned BW    = 128,
    parameter int unsigned IW    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       key_change,
    input  logic                       wr_en,
    input  logic [IW-1:0]              wr_idx,
    input  logic [BW-1:0]              wr_plain,
    input  logic [BW-1:0]              wr_cipher,
    output logic [N_ENT-1:0]           valid_o,
    output logic [N_ENT-1:0][BW-1:0]   plain_o,
    output logic [N_ENT-1:0][BW-1:0]   cipher_o
);

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        logic sel;
        assign sel = wr_en && (wr_idx == IW'(e));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_o[e]  <= 1'b0;
                plain_o[e]  <= '0;
                cipher_o[e] <= '0;
            end else if (key_change) begin
                valid_o[e]  <= 1'b0;
            end else if (sel) begin
                valid_o[e]  <= 1'b1;
                plain_o[e]  <= wr_plain;
                cipher_o[e] <= wr_cipher;
            end
        end
    end

    // R2
    fill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !key_change) |=> valid_o[$past(wr_idx)]);

endmodule

// File: rtl/fvm_cam_compare.sv
module fvm_cam_compare #(
    parameter int unsigned N_ENT  = 8,
    parameter int unsigned HALF_W = 64,
    parameter bit          WIDE   = 1'b1,
    parameter int unsigned BW     = 128
) (
    input  logic [N_ENT-1:0]           valid_i,
    input  logic [N_ENT-1:0][BW-1:0]   cipher_i,
    input  logic [BW-1:0]              key_i,
    output logic [N_ENT-1:0]           match_o
);

    for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
        if (WIDE) begin : g_pair
            logic lo_eq, hi_eq;
            assign lo_eq = cipher_i[e][HALF_W-1:0]    == key_i[HALF_W-1:0];
            assign hi_eq = cipher_i[e][BW-1:HALF_W]   == key_i[BW-1:HALF_W];
            assign match_o[e] = valid_i[e] && lo_eq && hi_eq;
        end else begin : g_single
            assign match_o[e] = valid_i[e] && (cipher_i[e] == key_i);
        end
    end

endmodule

// File: rtl/fvm_prio_pick.sv
module fvm_prio_pick #(
    parameter int unsigned N_ENT = 8,
    parameter int unsigned IW    = 3
) (
    input  logic [N_ENT-1:0] match_i,
    output logic             any_o,
    output logic [IW-1:0]    idx_o
);

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (match_i[i]) begin
                any_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/fvm_matcher.sv
module fvm_matcher
    import fvm_pkg::*;
#(
    parameter int unsigned N_ENT     = 8,
    parameter int unsigned HALF_W    = 64,
    parameter bit          WIDE_MODE = 1'b1,
    localparam int unsigned BLK_W    = blk_width(HALF_W, WIDE_MODE),
    localparam int unsigned IDX_W    = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_change,
    input  logic             fill_valid,
    input  logic [IDX_W-1:0] fill_index,
    input  logic [BLK_W-1:0] fill_plain,
    input  logic [BLK_W-1:0] fill_cipher,
    input  logic             lk_valid,
    input  logic             lk_map_bit,
    input  logic [BLK_W-1:0] lk_cipher,
    output logic             out_valid,
    output logic             out_hit,
    output logic [IDX_W-1:0] out_index,
    output logic [BLK_W-1:0] out_plain
);

    logic [N_ENT-1:0]             ent_valid;
    logic [N_ENT-1:0][BLK_W-1:0]  ent_plain;
    logic [N_ENT-1:0][BLK_W-1:0]  ent_cipher;
    logic [N_ENT-1:0]             ent_match;
    logic                         any_match;
    logic [IDX_W-1:0]             pick_idx;

    res_state_e       res_q, res_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [BLK_W-1:0] plain_q, plain_d;

    fvm_entry_store #(.N_ENT(N_ENT), .BW(BLK_W), .IW(IDX_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_change (key_change),
        .wr_en      (fill_valid),
        .wr_idx     (fill_index),
        .wr_plain   (fill_plain),
        .wr_cipher  (fill_cipher),
        .valid_o    (ent_valid),
        .plain_o    (ent_plain),
        .cipher_o   (ent_cipher)
    );

    fvm_cam_compare #(.N_ENT(N_ENT), .HALF_W(HALF_W), .WIDE(WIDE_MODE), .BW(BLK_W)) u_cmp (
        .valid_i  (ent_valid),
        .cipher_i (ent_cipher),
        .key_i    (lk_cipher),
        .match_o  (ent_match)
    );

    fvm_prio_pick #(.N_ENT(N_ENT), .IW(IDX_W)) u_pick (
        .match_i (ent_match),
        .any_o   (any_match),
        .idx_o   (pick_idx)
    );

    // next result state and captured data
    always_comb begin
        res_d   = RES_IDLE;
        idx_d   = '0;
        plain_d = '0;
        unique case ({lk_valid, lk_map_bit, any_match})
            3'b000, 3'b001, 3'b010, 3'b011: res_d = RES_IDLE;
            3'b100, 3'b101:                 res_d = RES_BYPASS;
            3'b110:                         res_d = RES_MISS;
            3'b111: begin
                res_d   = RES_HIT;
                idx_d   = pick_idx;
                plain_d = ent_plain[pick_idx];
            end
            default:                        res_d = RES_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= RES_IDLE;
            idx_q   <= '0;
            plain_q <= '0;
        end else begin
            res_q   <= res_d;
            idx_q   <= idx_d;
            plain_q <= plain_d;
        end
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        out_hit   = 1'b0;
        out_index = '0;
        out_plain = '0;
        unique case (res_q)
            RES_IDLE:   ;
            RES_BYPASS: out_valid = 1'b1;
            RES_MISS:   out_valid = 1'b1;
            RES_HIT: begin
                out_valid = 1'b1;
                out_hit   = 1'b1;
                out_index = idx_q;
                out_plain = plain_q;
            end
            default:    ;
        endcase
    end

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> out_valid);

    // R3
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !out_valid);

    // R4
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_map_bit) |=> (out_valid && !out_hit && out_plain == '0));

    // R5
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> (out_index == '0 && out_plain == '0));

    // R7
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_change ##1 lk_valid) |=> !out_hit);

endmodule

// File: tb/fvm_matcher_bench.sv
module fvm_matcher_bench;

    localparam int unsigned N  = 8;
    localparam int unsigned HW = 64;
    localparam int unsigned BW = 128;
    localparam int unsigned IW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          key_change, fill_valid, lk_valid, lk_map_bit;
    logic [IW-1:0] fill_index;
    logic [BW-1:0] fill_plain, fill_cipher, lk_cipher;
    logic          out_valid, out_hit;
    logic [IW-1:0] out_index;
    logic [BW-1:0] out_plain;

    int checks = 0;
    int failures = 0;

    logic          m_valid [N];
    logic [BW-1:0] m_plain [N];
    logic [BW-1:0] m_cipher[N];
    logic [BW-1:0] pool    [6];

    always #5 clk = ~clk;

    fvm_matcher #(.N_ENT(N), .HALF_W(HW), .WIDE_MODE(1'b1)) u_fvm_matcher (
        .clk(clk), .rst_n(rst_n), .key_change(key_change),
        .fill_valid(fill_valid), .fill_index(fill_index),
        .fill_plain(fill_plain), .fill_cipher(fill_cipher),
        .lk_valid(lk_valid), .lk_map_bit(lk_map_bit), .lk_cipher(lk_cipher),
        .out_valid(out_valid), .out_hit(out_hit),
        .out_index(out_index), .out_plain(out_plain)
    );

    function automatic logic [BW-1:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one cycle: inputs set at negedge, results checked at the following negedge
    task automatic step(input string tag, input logic kc, input logic fv,
                        input logic [IW-1:0] fi, input logic [BW-1:0] fp,
                        input logic [BW-1:0] fc, input logic lv, input logic lm,
                        input logic [BW-1:0] lc);
        logic          e_hit;
        logic [IW-1:0] e_idx;
        logic [BW-1:0] e_plain;
        key_change = kc; fill_valid = fv; fill_index = fi; fill_plain = fp;
        fill_cipher = fc; lk_valid = lv; lk_map_bit = lm; lk_cipher = lc;
        e_hit = 1'b0; e_idx = '0; e_plain = '0;
        if (lv && lm) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (m_valid[i] && m_cipher[i] == lc) begin
                    e_hit = 1'b1; e_idx = IW'(i); e_plain = m_plain[i];
                end
            end
        end
        @(posedge clk);
        if (kc) begin
            for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
        end else if (fv) begin
            m_valid[fi] = 1'b1; m_plain[fi] = fp; m_cipher[fi] = fc;
        end
        @(negedge clk);
        check(tag, "out_valid", BW'(out_valid), BW'(lv));
        if (lv) begin
            check(tag, "out_hit",   BW'(out_hit),   BW'(e_hit));
            check(tag, "out_index", BW'(out_index), BW'(e_idx));
            check(tag, "out_plain", out_plain, e_plain);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [BW-1:0] ca, cb, pa, pb, pc;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 1'b0; m_plain[i] = '0; m_cipher[i] = '0;
        end
        ca = rnd128(); cb = rnd128(); pa = rnd128(); pb = rnd128(); pc = rnd128();
        rst_n = 1'b0; key_change = 0; fill_valid = 0; fill_index = '0;
        fill_plain = '0; fill_cipher = '0; lk_valid = 0; lk_map_bit = 0; lk_cipher = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", "out_valid after reset", BW'(out_valid), '0);

        // R1: zero ciphertext must not hit zeroed invalid storage
        step("R1", 0, 0, 0, '0, '0, 1, 1, '0);
        // R3: idle cycle gives no result strobe
        step("R3", 0, 0, 0, '0, '0, 0, 0, '0);
        // R2: fill entry 3 then look it up
        step("R2", 0, 1, 3, pa, ca, 0, 0, '0);
        step("R2", 0, 0, 0, '0, '0, 1, 1, ca);
        // R4: map bit clear bypasses a matching block
        step("R4", 0, 0, 0, '0, '0, 1, 0, ca);
        // R5: unmatched ciphertext
        step("R5", 0, 0, 0, '0, '0, 1, 1, cb);
        // R6: duplicate ciphertext in entry 1, lowest wins
        step("R6", 0, 1, 1, pb, ca, 0, 0, '0);
        step("R6", 0, 0, 0, '0, '0, 1, 1, ca);
        // R8: overwrite entry 1 while looking up its old ciphertext
        step("R8", 0, 1, 1, pc, cb, 1, 1, ca);
        step("R8", 0, 0, 0, '0, '0, 1, 1, ca);
        step("R8", 0, 0, 0, '0, '0, 1, 1, cb);
        // R9: only one 64-bit half matches
        step("R9", 0, 0, 0, '0, '0, 1, 1, {cb[127:64], ~cb[63:0]});
        step("R9", 0, 0, 0, '0, '0, 1, 1, {~ca[127:64], ca[63:0]});
        // R7: key change with a same-cycle fill and lookup
        step("R7", 1, 1, 2, pa, ca, 1, 1, cb);
        step("R7", 0, 0, 0, '0, '0, 1, 1, ca);
        step("R7", 0, 0, 0, '0, '0, 1, 1, cb);

        // random phase, mixed requirements
        for (int i = 0; i < 6; i++) pool[i] = rnd128();
        for (int n = 0; n < 600; n++) begin
            logic [BW-1:0] lc;
            lc = ($urandom % 8 == 0) ? rnd128() : pool[$urandom % 6];
            step("R2/R6 random", ($urandom % 60) == 0, ($urandom % 3) == 0,
                 IW'($urandom), rnd128(), pool[$urandom % 6],
                 ($urandom % 4) != 0, ($urandom % 5) != 0, lc);
        end
        finish_run();
    end

endmodule